// File: doc/BRIEF.md
# Low-Power Mode Controller

This block decides which parts of a small microcontroller receive clock and power enables. It switches between three modes: run, idle and halt. Software writes a control register to ask for idle or halt. The block then drives enable outputs for the instruction core clock, the oscillator, the PLL, the periodic wake counter, the comparator and the brown-out detector.

In idle, the instruction core is gated and both analog monitors are switched off. The oscillator, the PLL and the wake counter keep running. Idle ends on its own when the free-running 8192-cycle wake counter wraps. It also ends early on a rising edge of any enabled wakeup input. Halt also stops the oscillator, the PLL and the wake counter, so only a wakeup input can end it.

Each exit leaves its cause in a sticky status register, and software must clear that register afterwards. A halt request is refused while the PLL is still requested on. The refusal is recorded as an error flag in the same status register.

Top module: `lpm_ctrl`

## Requirements
- R1: After reset the block is in run mode. Core, oscillator, wake-counter, comparator and brown-out enables are 1, the PLL enable follows `pll_req_i`, and the status register reads 0.
- R2: In run mode, a write to the control register (`wr_sel`=0) with bit 0 set and bit 1 clear enters idle at that clock edge. In idle, core, comparator and brown-out enables are 0, oscillator and wake-counter enables are 1, and the PLL enable follows `pll_req_i`.
- R3: The control register always reads 0. Once idle has been left, the block stays in run until a new idle request is written.
- R4: The wake counter runs freely in run and idle and wraps every 8192 cycles. A wrap during idle returns to run and sets status bit 0. Two back-to-back timer exits are exactly 8192 cycles apart.
- R5: A rising edge on a wakeup input whose mask bit is 1 returns idle to run. The input passes two synchronizing flops and an edge detector, so the core enable is 0 two edges after the input rises and 1 at the third. Status bit 1 is set. Edges on inputs whose mask bit is 0 have no effect.
- R6: A wakeup input held high causes only one exit. Entering idle again while it stays high does not wake the block.
- R7: In run mode, a control write with bit 1 set while `pll_req_i` is 0 enters halt. In halt, every enable output is 0.
- R8: A halt request while `pll_req_i` is 1 is refused. The block stays in run and status bit 2 is set.
- R9: Halt ends only on a masked wakeup edge, which sets status bit 1. The wake counter is stopped in halt, so no timer exit can occur there.
- R10: Status bits are sticky. Only a write of 0x00 to the status register (`wr_sel`=1) clears them, and a write of any nonzero value leaves them unchanged.
- R11: A control write with both bit 0 and bit 1 set is treated as a halt request.
- R12: Control writes made while in idle or halt are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 control, 1 status |
| wr_data | input | REG_W | Write data (control bit 0 idle, bit 1 halt) |
| rd_sel | input | 1 | Read target: 0 control, 1 status |
| rd_data | output | REG_W | Read data (status bit 0 timer, bit 1 wakeup, bit 2 halt error) |
| pll_req_i | input | 1 | PLL enable as configured by software |
| wake_i | input | WAKE_W | Asynchronous wakeup inputs |
| wake_mask_i | input | WAKE_W | Per-input wakeup enable |
| core_clk_en_o | output | 1 | Instruction core clock enable |
| osc_en_o | output | 1 | Oscillator enable |
| pll_en_o | output | 1 | PLL enable |
| wake_tmr_en_o | output | 1 | Wake counter enable |
| cmp_en_o | output | 1 | Comparator enable |
| bor_en_o | output | 1 | Brown-out detector enable |

## Verification
The assertions check several rules on every cycle. Idle must leave on the edge after a trigger, and halt must ignore everything but a wakeup edge. A refused halt must keep run and set the error flag. Status bits must stay set until a clear write, the counter must hold while stopped, and edge pulses must last one cycle. Only the bench scenarios can show the rest. These include the exact 8192-cycle gap between timer exits and the two-stage synchronizer latency. They also cover the single wake from a held input, the mask, and the enable pattern of each mode.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  typedef enum logic [1:0] {
    MODE_RUN  = 2'd0,
    MODE_IDLE = 2'd1,
    MODE_HALT = 2'd2
  } lpm_mode_e;

  // control register bit positions
  localparam int unsigned CTL_IDLE = 0;
  localparam int unsigned CTL_HALT = 1;

  // status register bit positions
  localparam int unsigned ST_TMR  = 0;
  localparam int unsigned ST_WAKE = 1;
  localparam int unsigned ST_HERR = 2;
  localparam int unsigned ST_W    = 3;
endpackage

// File: rtl/lpm_wake_sync.sv
module lpm_wake_sync #(
  parameter int unsigned WAKE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WAKE_W-1:0] wake_i,
  output logic [WAKE_W-1:0] rise_o
);
  for (genvar g = 0; g < WAKE_W; g++) begin : g_line
    logic s1_q, s2_q, s3_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1_q <= 1'b0;
        s2_q <= 1'b0;
        s3_q <= 1'b0;
      end else begin
        s1_q <= wake_i[g];
        s2_q <= s1_q;
        s3_q <= s2_q;
      end
    end

    assign rise_o[g] = s2_q & ~s3_q;

    // an edge pulse lasts exactly one cycle (basis of R6)
    p_rise_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o[g] |=> !rise_o[g]);
  end
endmodule

// File: rtl/lpm_wake_timer.sv
module lpm_wake_timer #(
  parameter int unsigned TMR_W = 13
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  output logic ovf_o
);
  localparam logic [TMR_W-1:0] CNT_MAX = {TMR_W{1'b1}};

  logic [TMR_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (en_i) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign ovf_o = en_i && (cnt_q == CNT_MAX);

  // counter frozen while not enabled (R9: no timer exit from halt)
  p_cnt_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> $stable(cnt_q));
endmodule

// File: rtl/lpm_mode_fsm.sv
module lpm_mode_fsm
  import lpm_pkg::*;
#(
  parameter int unsigned REG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [REG_W-1:0] wr_data,
  input  logic             pll_req_i,
  input  logic             wake_evt_i,
  input  logic             tmr_ovf_i,
  output lpm_mode_e        mode_o,
  output logic [ST_W-1:0]  status_o
);
  lpm_mode_e       mode_q, mode_d;
  logic [ST_W-1:0] st_q, st_d, st_set;
  logic            ctl_wr, st_clr;

  assign ctl_wr = wr_en && !wr_sel;
  assign st_clr = wr_en && wr_sel && (wr_data == '0);

  always_comb begin
    mode_d = mode_q;
    st_set = '0;
    unique case (mode_q)
      MODE_RUN: begin
        if (ctl_wr) begin
          if (wr_data[CTL_HALT]) begin
            if (!pll_req_i) mode_d = MODE_HALT;
            else            st_set[ST_HERR] = 1'b1;
          end else if (wr_data[CTL_IDLE]) begin
            mode_d = MODE_IDLE;
          end
        end
      end
      MODE_IDLE: begin
        if (tmr_ovf_i || wake_evt_i) begin
          mode_d           = MODE_RUN;
          st_set[ST_TMR]  = tmr_ovf_i;
          st_set[ST_WAKE] = wake_evt_i;
        end
      end
      MODE_HALT: begin
        if (wake_evt_i) begin
          mode_d           = MODE_RUN;
          st_set[ST_WAKE] = 1'b1;
        end
      end
      default: mode_d = MODE_RUN;
    endcase
    st_d = (st_clr ? '0 : st_q) | st_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_RUN;
      st_q   <= '0;
    end else begin
      mode_q <= mode_d;
      st_q   <= st_d;
    end
  end

  assign mode_o   = mode_q;
  assign status_o = st_q;

  p_idle_exit_next_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_IDLE && (wake_evt_i || tmr_ovf_i)) |=> (mode_q == MODE_RUN));

  p_halt_refused_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_RUN && ctl_wr && wr_data[CTL_HALT] && pll_req_i)
      |=> (mode_q == MODE_RUN && st_q[ST_HERR]));

  p_halt_wake_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_HALT && !wake_evt_i) |=> (mode_q == MODE_HALT));

  p_idle_ignores_ctl_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_IDLE && !wake_evt_i && !tmr_ovf_i) |=> (mode_q == MODE_IDLE));

  p_status_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !st_clr |=> ((st_q & $past(st_q)) == $past(st_q)));
endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
  import lpm_pkg::*;
#(
  parameter int unsigned WAKE_W = 4,
  parameter int unsigned TMR_W  = 13,
  parameter int unsigned REG_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [REG_W-1:0]  wr_data,
  input  logic              rd_sel,
  output logic [REG_W-1:0]  rd_data,
  input  logic              pll_req_i,
  input  logic [WAKE_W-1:0] wake_i,
  input  logic [WAKE_W-1:0] wake_mask_i,
  output logic              core_clk_en_o,
  output logic              osc_en_o,
  output logic              pll_en_o,
  output logic              wake_tmr_en_o,
  output logic              cmp_en_o,
  output logic              bor_en_o
);
  localparam int unsigned PAD_W = REG_W - ST_W;

  logic              rs1_q, rs2_q, rst_int_n;
  logic [WAKE_W-1:0] rise;
  logic              wake_evt, tmr_ovf, tmr_en;
  lpm_mode_e         mode;
  logic [ST_W-1:0]   status;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  end
  assign rst_int_n = rs2_q;

  lpm_wake_sync #(.WAKE_W(WAKE_W)) u_sync (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .wake_i (wake_i),
    .rise_o (rise)
  );

  assign wake_evt = |(rise & wake_mask_i);
  assign tmr_en   = (mode != MODE_HALT);

  lpm_wake_timer #(.TMR_W(TMR_W)) u_tmr (
    .clk   (clk),
    .rst_n (rst_int_n),
    .en_i  (tmr_en),
    .ovf_o (tmr_ovf)
  );

  lpm_mode_fsm #(.REG_W(REG_W)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .wr_en      (wr_en),
    .wr_sel     (wr_sel),
    .wr_data    (wr_data),
    .pll_req_i  (pll_req_i),
    .wake_evt_i (wake_evt),
    .tmr_ovf_i  (tmr_ovf),
    .mode_o     (mode),
    .status_o   (status)
  );

  // control bits are write-only and always read as zero
  assign rd_data = rd_sel ? {{PAD_W{1'b0}}, status} : '0;

  assign core_clk_en_o = (mode == MODE_RUN);
  assign cmp_en_o      = (mode == MODE_RUN);
  assign bor_en_o      = (mode == MODE_RUN);
  assign osc_en_o      = (mode != MODE_HALT);
  assign wake_tmr_en_o = tmr_en;
  assign pll_en_o      = pll_req_i && (mode != MODE_HALT);
endmodule

// File: tb/sim_lpm_ctrl.sv
`timescale 1ns/1ps
module sim_lpm_ctrl;
  localparam int WAKE_W = 4;
  localparam int REG_W  = 8;
  localparam int PERIOD = 8192;
  localparam int MAX_CYC = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, wr_sel = 1'b0, rd_sel = 1'b1;
  logic [REG_W-1:0] wr_data = '0;
  logic [REG_W-1:0] rd_data;
  logic pll_req = 1'b1;
  logic [WAKE_W-1:0] wake = '0;
  logic [WAKE_W-1:0] wmask = 4'b0001;
  logic core_en, osc_en, pll_en, tmr_en, cmp_en, bor_en;

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  lpm_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .pll_req_i(pll_req), .wake_i(wake),
    .wake_mask_i(wmask), .core_clk_en_o(core_en), .osc_en_o(osc_en),
    .pll_en_o(pll_en), .wake_tmr_en_o(tmr_en), .cmp_en_o(cmp_en), .bor_en_o(bor_en)
  );

  // {core, osc, pll, tmr, cmp, bor}
  function automatic logic [5:0] ens();
    return {core_en, osc_en, pll_en, tmr_en, cmp_en, bor_en};
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic sel, input logic [REG_W-1:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic wake_pulse();
    wake[0] = 1'b1; tick(3);
    wake[0] = 1'b0; tick(3);
  endtask

  task automatic wait_run(output int t);
    int n = 0;
    while (!core_en && n < PERIOD + 16) begin tick(1); n++; end
    t = cyc;
  endtask

  // {pll_req, ctl[1:0], enables[5:0], status[2:0]}
  localparam logic [11:0] VEC [8] = '{
    {1'b1, 2'b01, 6'b011100, 3'b000},
    {1'b0, 2'b01, 6'b010100, 3'b000},
    {1'b0, 2'b10, 6'b000000, 3'b000},
    {1'b1, 2'b10, 6'b111111, 3'b100},
    {1'b0, 2'b11, 6'b000000, 3'b000},
    {1'b1, 2'b11, 6'b111111, 3'b100},
    {1'b1, 2'b00, 6'b111111, 3'b000},
    {1'b0, 2'b00, 6'b110111, 3'b000}
  };

  initial begin : watchdog
    repeat (MAX_CYC) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", MAX_CYC, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : main
    int t1, t2;
    tick(3);
    rst_n = 1'b1;
    tick(4);
    // R1 reset state
    chk(ens() == 6'b111111, "R1 enables", ens(), 6'b111111);
    chk(rd_data == 8'h00, "R1 status", rd_data, 0);

    // R4 timer exits, 8192 apart
    wr(0, 8'h01);
    chk(core_en == 1'b0, "R2 idle entered", core_en, 0);
    rd_sel = 1'b0; #1;
    chk(rd_data == 8'h00, "R3 ctrl reads 0", rd_data, 0);
    rd_sel = 1'b1;
    wait_run(t1);
    chk(core_en == 1'b1, "R4 first timer exit", core_en, 1);
    chk(rd_data == 8'h01, "R4 status timer", rd_data, 1);
    wr(1, 8'h00);
    chk(rd_data == 8'h00, "R10 clear by zero", rd_data, 0);
    tick(3);
    chk(core_en == 1'b1, "R3 no self re-idle", core_en, 1);
    wr(0, 8'h01);
    wait_run(t2);
    chk(t2 - t1 == PERIOD, "R4 exit spacing", t2 - t1, PERIOD);
    wr(1, 8'h00);

    // table of mode requests (R2 R7 R8 R11)
    for (int i = 0; i < 8; i++) begin
      logic [11:0] v;
      v = VEC[i];
      pll_req = v[11];
      tick(1);
      wr(0, {6'b0, v[10:9]});
      chk(ens() == v[8:3], $sformatf("R2/R7/R8/R11 vec%0d enables", i), ens(), v[8:3]);
      chk(rd_data[2:0] == v[2:0], $sformatf("R8 vec%0d status", i), rd_data, v[2:0]);
      if (!core_en) wake_pulse();
      wr(1, 8'h00);
      pll_req = 1'b1;
      tick(1);
      chk(core_en == 1'b1, $sformatf("R9 vec%0d back to run", i), core_en, 1);
    end

    // R5 exact wake latency and status
    wr(0, 8'h01);
    wake[0] = 1'b1;
    tick(2);
    chk(core_en == 1'b0, "R5 still idle after 2 edges", core_en, 0);
    tick(1);
    chk(core_en == 1'b1, "R5 run at 3rd edge", core_en, 1);
    chk(rd_data == 8'h02, "R5 status wake", rd_data, 2);
    // R10 nonzero write leaves status
    wr(1, 8'h05);
    chk(rd_data == 8'h02, "R10 nonzero write ignored", rd_data, 2);
    wr(1, 8'h00);
    chk(rd_data == 8'h00, "R10 zero write clears", rd_data, 0);

    // R6 held-high input does not re-wake
    wr(0, 8'h01);
    tick(6);
    chk(core_en == 1'b0, "R6 held input no re-wake", core_en, 0);
    wake[0] = 1'b0; tick(3);
    wake_pulse();
    chk(core_en == 1'b1, "R6 fresh edge wakes", core_en, 1);
    wr(1, 8'h00);

    // R5 masked-off input ignored
    wr(0, 8'h01);
    wake[1] = 1'b1; tick(4); wake[1] = 1'b0; tick(2);
    chk(core_en == 1'b0, "R5 unmasked input ignored", core_en, 0);

    // R12 control write in idle ignored
    pll_req = 1'b0;
    tick(1);
    wr(0, 8'h02);
    chk(ens() == 6'b010100, "R12 idle ignores halt write", ens(), 6'b010100);
    wake_pulse();
    wr(1, 8'h00);

    // R12 write in halt, R9 long halt without timer exit
    wr(0, 8'h02);
    chk(ens() == 6'b000000, "R7 halt all off", ens(), 0);
    wr(0, 8'h01);
    chk(ens() == 6'b000000, "R12 halt ignores idle write", ens(), 0);
    tick(PERIOD + 800);
    chk(ens() == 6'b000000, "R9 no timer exit from halt", ens(), 0);
    chk(rd_data == 8'h00, "R9 status untouched in halt", rd_data, 0);
    wake_pulse();
    chk(core_en == 1'b1, "R9 wake exits halt", core_en, 1);
    chk(rd_data == 8'h02, "R9 status wake bit", rd_data, 2);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule